// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block performs a complete trap entry in one clock cycle. When a trap request arrives with a 9-bit trap type, it checks the current trap level against a configurable ceiling. It raises the level, and on the last permitted step it flags the reduced-reliability condition. It records the interrupted context on a per-level trap stack and rewrites the processor-state and hyper-state registers according to the class of the trap. It then emits a redirect strobe with the new fetch address and the next-fetch address.

The block owns the trap level, the processor-state word, the hyper-state word and the trap stack. Condition codes, the address-space identifier, the window pointer, the interrupted PC/NPC and the two vector base registers come in from the rest of the core. A read port gives the stack entry at any level, so that trap-return logic and debug can use it. If a trap arrives when the level is already at the ceiling, the block raises a sticky error-state flag and changes nothing else.

Top module: `trap_entry_seq`

## Requirements
- R1: A request while the trap level is at or above MAX_TL sets errorState, which stays set until reset. It leaves the trap level, the processor state, the hyper state and the stack untouched, and produces no redirect.
- R2: An accepted request raises the trap level by one. When the level before the request equals MAX_TL-1, the reduced-reliability bit (processor-state bit 5, value 0x020) is ORed into the state word before it is saved.
- R3: The saved-state word is 40 bits. Bits 39:32 hold the condition codes and bits 31:24 the address-space identifier. Bits 19:8 hold the processor state (with the bit from R2) ANDed with 0xF3F. Bits 4:0 hold the window pointer. All other bits are zero.
- R4: The stack entry indexed by the new trap level stores the saved-state word, the interrupted PC, the interrupted NPC and the trap type. The rdLevel port reads that entry combinationally.
- R5: With hyperPresent high, the hyper state from before the trap is stored at the new level. Hyper-privilege (hyper-state bit 2, value 0x004) is forced on when the new level exceeds 2.
- R6: Trap type 0x060 without a hypervisor sets the processor state to 0x814 (enable-FP 0x010, privileged 0x004, interrupt globals 0x800). With a hypervisor it leaves the processor state as it was after R2.
- R7: Types 0x008, 0x030 and 0x064..0x06F set the processor state to 0x414 (MMU globals 0x400) without a hypervisor. With a hypervisor they set the processor state to 0x014 and set hyper-privilege.
- R8: Types 0x03E, 0x03F and 0x180..0x1FF only set hyper-privilege. Every other type sets the processor state to 0x015 (alternate globals 0x001).
- R9: With hyperMode high, the new PC is the hyper base with bits 13:0 cleared, ORed with the trap type shifted left by 5.
- R10: With hyperMode low, the new PC is the trap base with bits 14:0 cleared, with bit 14 set when the new level exceeds 1, ORed with the trap type shifted left by 5. The new NPC is always the new PC plus 4.
- R11: redirectValid is high for exactly the one cycle after each accepted request, and the new registers and redirect addresses are visible in that same cycle.
- R12: After reset the trap level is 0, the processor state is 0x014, the hyper state is 0, errorState and redirectValid are low, and every stack entry reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Trap request, one cycle per trap |
| trapType | input | 9 | Trap type of the request |
| hyperPresent | input | 1 | A hypervisor layer exists |
| hyperMode | input | 1 | Vector from the hyper base |
| ccr | input | 8 | Current condition codes |
| asi | input | 8 | Current address-space identifier |
| cwp | input | 5 | Current window pointer |
| curPc | input | 64 | PC of the interrupted instruction |
| curNpc | input | 64 | Next PC of the interrupted instruction |
| trapBase | input | 64 | Trap base address |
| hyperBase | input | 64 | Hyper trap base address |
| rdLevel | input | 3 | Stack read index |
| trapLevel | output | 3 | Current trap level |
| procState | output | 12 | Processor-state word |
| hyperState | output | 12 | Hyper-state word |
| errorState | output | 1 | Sticky error-state flag |
| redirectValid | output | 1 | One-cycle redirect strobe |
| redirectPc | output | 64 | New fetch address |
| redirectNpc | output | 64 | New next-fetch address |
| rdTstate | output | 40 | Saved-state word at rdLevel |
| rdTpc | output | 64 | Saved PC at rdLevel |
| rdTnpc | output | 64 | Saved NPC at rdLevel |
| rdTt | output | 9 | Saved trap type at rdLevel |
| rdHtstate | output | 12 | Saved hyper state at rdLevel |

## Verification
Every internal register of this block reaches a port within one cycle. A wrong level count shows up on the trap-level output and in bit 14 of the next vector. It also shows as the stack entry landing at the wrong rdLevel, and as the error flag rising one trap early or late. A class-decode mistake shows in the processor-state or hyper-state word in the cycle of the redirect. A stale processor-state value is carried into the saved word of the next trap. The bench therefore checks every output in the redirect cycle, and at the end of each run it reads back every stack level to catch overwrites of older entries.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    CLS_IVEC = 2'd0,
    CLS_MMU  = 2'd1,
    CLS_HYP  = 2'd2,
    CLS_GEN  = 2'd3
  } trapClass_t;

  typedef struct packed {
    logic       enter;
    logic       setRed;
    logic       hypForce;
    trapClass_t cls;
  } tcStrobe_t;

  localparam int PS_W     = 12;
  localparam int SAVED_W  = 40;
  localparam int TT_W     = 9;

  localparam logic [PS_W-1:0] PS_ALTG   = 12'h001;
  localparam logic [PS_W-1:0] PS_PRIVB  = 12'h004;
  localparam logic [PS_W-1:0] PS_FPEN   = 12'h010;
  localparam logic [PS_W-1:0] PS_REDB   = 12'h020;
  localparam logic [PS_W-1:0] PS_MMUG   = 12'h400;
  localparam logic [PS_W-1:0] PS_INTG   = 12'h800;
  localparam logic [PS_W-1:0] PS_SAVMSK = 12'hF3F;
  localparam logic [PS_W-1:0] PS_RESET  = 12'h014;
  localparam logic [PS_W-1:0] HS_HPRIV  = 12'h004;

  localparam logic [TT_W-1:0] TT_IVEC_C   = 9'h060;
  localparam logic [TT_W-1:0] TT_IFAULT_C = 9'h008;
  localparam logic [TT_W-1:0] TT_DFAULT_C = 9'h030;
  localparam logic [TT_W-1:0] TT_MMULO_C  = 9'h064;
  localparam logic [TT_W-1:0] TT_MMUHI_C  = 9'h06F;
  localparam logic [TT_W-1:0] TT_RTLO_C   = 9'h03E;
  localparam logic [TT_W-1:0] TT_RTHI_C   = 9'h03F;
  localparam logic [TT_W-1:0] TT_HTLO_C   = 9'h180;

  function automatic trapClass_t classifyTrap(input logic [TT_W-1:0] tt);
    if (tt == TT_IVEC_C)                              return CLS_IVEC;
    if (tt == TT_IFAULT_C || tt == TT_DFAULT_C)       return CLS_MMU;
    if (tt >= TT_MMULO_C && tt <= TT_MMUHI_C)         return CLS_MMU;
    if (tt >= TT_RTLO_C && tt <= TT_RTHI_C)           return CLS_HYP;
    if (tt >= TT_HTLO_C)                              return CLS_HYP;
    return CLS_GEN;
  endfunction

endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int TLW    = $clog2(MAX_TL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapReq,
  input  logic [TT_W-1:0] trapType,
  input  logic            hyperPresent,
  output logic [TLW-1:0]  trapLevel,
  output logic [TLW-1:0]  newTl,
  output logic            errorState,
  output tcStrobe_t       strobe
);

  localparam logic [TLW-1:0] TL_CEIL = TLW'(MAX_TL);
  localparam logic [TLW-1:0] TL_LAST = TLW'(MAX_TL - 1);
  localparam logic [TLW-1:0] TL_HFRC = TLW'(2);

  logic atCeil;

  always_comb begin
    atCeil          = (trapLevel >= TL_CEIL);
    newTl           = trapLevel + TLW'(1);
    strobe.enter    = trapReq && !atCeil;
    strobe.setRed   = (trapLevel >= TL_LAST);
    strobe.hypForce = hyperPresent && (newTl > TL_HFRC);
    strobe.cls      = classifyTrap(trapType);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapLevel  <= '0;
      errorState <= 1'b0;
    end else begin
      if (strobe.enter)       trapLevel  <= newTl;
      if (trapReq && atCeil)  errorState <= 1'b1;
    end
  end

  // R1: a request at the ceiling raises the error flag and freezes the level
  a_r1_ceiling_error : assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && trapLevel >= TL_CEIL) |=> (errorState && trapLevel == $past(trapLevel)));

  // R1: once raised, the error flag stays high
  a_r1_error_sticky : assert property (@(posedge clk) disable iff (!rstN)
    errorState |=> errorState);

  // R2: each accepted trap raises the level by exactly one
  a_r2_level_step : assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && trapLevel < TL_CEIL) |=> (trapLevel == $past(trapLevel) + TLW'(1)));

  // R2: level never passes the ceiling
  a_r2_level_bound : assert property (@(posedge clk) disable iff (!rstN)
    trapLevel <= TL_CEIL);

endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int TLW    = $clog2(MAX_TL + 1),
  parameter int PC_W   = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  tcStrobe_t          strobe,
  input  logic [TLW-1:0]     newTl,
  input  logic [TT_W-1:0]    trapType,
  input  logic               hyperPresent,
  input  logic               hyperMode,
  input  logic [7:0]         ccr,
  input  logic [7:0]         asi,
  input  logic [4:0]         cwp,
  input  logic [PC_W-1:0]    curPc,
  input  logic [PC_W-1:0]    curNpc,
  input  logic [PC_W-1:0]    trapBase,
  input  logic [PC_W-1:0]    hyperBase,
  input  logic [TLW-1:0]     rdLevel,
  output logic [PS_W-1:0]    procState,
  output logic [PS_W-1:0]    hyperState,
  output logic               redirectValid,
  output logic [PC_W-1:0]    redirectPc,
  output logic [PC_W-1:0]    redirectNpc,
  output logic [SAVED_W-1:0] rdTstate,
  output logic [PC_W-1:0]    rdTpc,
  output logic [PC_W-1:0]    rdTnpc,
  output logic [TT_W-1:0]    rdTt,
  output logic [PS_W-1:0]    rdHtstate
);

  localparam int DEPTH = 1 << TLW;
  localparam logic [PC_W-1:0] HB_MASK = ~PC_W'(64'h3FFF);
  localparam logic [PC_W-1:0] TB_MASK = ~PC_W'(64'h7FFF);
  localparam logic [PC_W-1:0] TL_BIT  = PC_W'(64'h4000);

  logic [SAVED_W-1:0] tsWord [DEPTH];
  logic [PC_W-1:0]    tsPc   [DEPTH];
  logic [PC_W-1:0]    tsNpc  [DEPTH];
  logic [TT_W-1:0]    tsTt   [DEPTH];
  logic [PS_W-1:0]    tsHt   [DEPTH];

  logic [PS_W-1:0]    psRed, psNext, hpNext;
  logic [SAVED_W-1:0] savedWord;
  logic [PC_W-1:0]    ttOff, pcVec;

  // processor-state view with the reduced-reliability bit folded in
  always_comb begin
    psRed     = procState | (strobe.setRed ? PS_REDB : '0);
    savedWord = {ccr, asi, 4'b0000, psRed & PS_SAVMSK, 3'b000, cwp};
  end

  // class-dependent rewrite of the state words
  always_comb begin
    hpNext = hyperState | (strobe.hypForce ? HS_HPRIV : '0);
    psNext = psRed;
    unique case (strobe.cls)
      CLS_IVEC: if (!hyperPresent) psNext = PS_FPEN | PS_PRIVB | PS_INTG;
      CLS_MMU: begin
        if (hyperPresent) begin
          hpNext = hpNext | HS_HPRIV;
          psNext = PS_FPEN | PS_PRIVB;
        end else begin
          psNext = PS_FPEN | PS_PRIVB | PS_MMUG;
        end
      end
      CLS_HYP: hpNext = hpNext | HS_HPRIV;
      default: psNext = PS_FPEN | PS_PRIVB | PS_ALTG;
    endcase
  end

  // vector address
  always_comb begin
    ttOff = PC_W'(trapType) << 5;
    if (hyperMode) pcVec = (hyperBase & HB_MASK) | ttOff;
    else           pcVec = (trapBase & TB_MASK) | ((newTl > TLW'(1)) ? TL_BIT : '0) | ttOff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      procState     <= PS_RESET;
      hyperState    <= '0;
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      redirectNpc   <= '0;
    end else begin
      redirectValid <= strobe.enter;
      if (strobe.enter) begin
        procState   <= psNext;
        hyperState  <= hpNext;
        redirectPc  <= pcVec;
        redirectNpc <= pcVec + PC_W'(4);
      end
    end
  end

  // trap stack, one entry per level
  for (genvar e = 0; e < DEPTH; e++) begin : g_stack
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tsWord[e] <= '0;
        tsPc[e]   <= '0;
        tsNpc[e]  <= '0;
        tsTt[e]   <= '0;
        tsHt[e]   <= '0;
      end else if (strobe.enter && newTl == TLW'(e)) begin
        tsWord[e] <= savedWord;
        tsPc[e]   <= curPc;
        tsNpc[e]  <= curNpc;
        tsTt[e]   <= trapType;
        if (hyperPresent) tsHt[e] <= hyperState;
      end
    end
  end

  always_comb begin
    rdTstate  = tsWord[rdLevel];
    rdTpc     = tsPc[rdLevel];
    rdTnpc    = tsNpc[rdLevel];
    rdTt      = tsTt[rdLevel];
    rdHtstate = tsHt[rdLevel];
  end

  // R11: strobe follows an accepted request by exactly one cycle
  a_r11_strobe_follows : assert property (@(posedge clk) disable iff (!rstN)
    strobe.enter |=> redirectValid);

  a_r11_strobe_single : assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enter |=> !redirectValid);

  // R10: next-fetch address trails the fetch address by one word
  a_r10_npc_step : assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (redirectNpc == redirectPc + PC_W'(4)));

  // R5: deep levels under a hypervisor end hyper-privileged
  a_r5_hyper_force : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enter && strobe.hypForce) |=> ((hyperState & HS_HPRIV) != '0));

  // R1: state words hold when no trap is entered
  a_r1_state_hold : assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enter |=> ($stable(procState) && $stable(hyperState)));

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int PC_W   = 64,
  parameter int TLW    = $clog2(MAX_TL + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapReq,
  input  logic [TT_W-1:0]    trapType,
  input  logic               hyperPresent,
  input  logic               hyperMode,
  input  logic [7:0]         ccr,
  input  logic [7:0]         asi,
  input  logic [4:0]         cwp,
  input  logic [PC_W-1:0]    curPc,
  input  logic [PC_W-1:0]    curNpc,
  input  logic [PC_W-1:0]    trapBase,
  input  logic [PC_W-1:0]    hyperBase,
  input  logic [TLW-1:0]     rdLevel,
  output logic [TLW-1:0]     trapLevel,
  output logic [PS_W-1:0]    procState,
  output logic [PS_W-1:0]    hyperState,
  output logic               errorState,
  output logic               redirectValid,
  output logic [PC_W-1:0]    redirectPc,
  output logic [PC_W-1:0]    redirectNpc,
  output logic [SAVED_W-1:0] rdTstate,
  output logic [PC_W-1:0]    rdTpc,
  output logic [PC_W-1:0]    rdTnpc,
  output logic [TT_W-1:0]    rdTt,
  output logic [PS_W-1:0]    rdHtstate
);

  tcStrobe_t      strobe;
  logic [TLW-1:0] newTl;

  trap_entry_ctrl #(.MAX_TL(MAX_TL), .TLW(TLW)) u_ctrl (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
    .hyperPresent(hyperPresent), .trapLevel(trapLevel), .newTl(newTl),
    .errorState(errorState), .strobe(strobe)
  );

  trap_entry_dp #(.MAX_TL(MAX_TL), .TLW(TLW), .PC_W(PC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .newTl(newTl),
    .trapType(trapType), .hyperPresent(hyperPresent), .hyperMode(hyperMode),
    .ccr(ccr), .asi(asi), .cwp(cwp), .curPc(curPc), .curNpc(curNpc),
    .trapBase(trapBase), .hyperBase(hyperBase), .rdLevel(rdLevel),
    .procState(procState), .hyperState(hyperState),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .redirectNpc(redirectNpc), .rdTstate(rdTstate), .rdTpc(rdTpc),
    .rdTnpc(rdTnpc), .rdTt(rdTt), .rdHtstate(rdHtstate)
  );

endmodule

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;

  localparam int MAXL = 6;
  localparam int TW   = 3;

  logic        clk = 1'b0;
  logic        rstN, trapReq, hyperPresent, hyperMode;
  logic [8:0]  trapType;
  logic [7:0]  ccr, asi;
  logic [4:0]  cwp;
  logic [63:0] curPc, curNpc, trapBase, hyperBase;
  logic [TW-1:0] rdLevel, trapLevel;
  logic [11:0] procState, hyperState, rdHtstate;
  logic        errorState, redirectValid;
  logic [63:0] redirectPc, redirectNpc, rdTpc, rdTnpc;
  logic [39:0] rdTstate;
  logic [8:0]  rdTt;

  int total = 0, fails = 0;
  bit finished = 0;

  // bench model
  int          mTl;
  logic [11:0] mPs, mHp;
  logic [39:0] mWord [8];
  logic [63:0] mPc [8], mNpc [8];
  logic [8:0]  mTt [8];
  logic [11:0] mHt [8];

  trap_entry_seq u_dut (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
    .hyperPresent(hyperPresent), .hyperMode(hyperMode), .ccr(ccr), .asi(asi),
    .cwp(cwp), .curPc(curPc), .curNpc(curNpc), .trapBase(trapBase),
    .hyperBase(hyperBase), .rdLevel(rdLevel), .trapLevel(trapLevel),
    .procState(procState), .hyperState(hyperState), .errorState(errorState),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .redirectNpc(redirectNpc), .rdTstate(rdTstate), .rdTpc(rdTpc),
    .rdTnpc(rdTnpc), .rdTt(rdTt), .rdHtstate(rdHtstate)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // 0 = interrupt vector, 1 = mmu, 2 = hyper-only, 3 = general
  function automatic int kindOf(input logic [8:0] tt);
    if (tt == 9'h060) return 0;
    if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) return 1;
    if (tt == 9'h03E || tt == 9'h03F || tt >= 9'h180) return 2;
    return 3;
  endfunction

  function automatic logic [63:0] vecOf(input logic hm, input logic [8:0] tt, input int lvl);
    logic [63:0] off = {55'd0, tt} << 5;
    if (hm) return (hyperBase & ~64'h3FFF) | off;
    return (trapBase & ~64'h7FFF) | ((lvl > 1) ? 64'h4000 : 64'h0) | off;
  endfunction

  function automatic logic [8:0] pickType();
    int r = $urandom % 10;
    int s = $urandom;
    case (r)
      0: return 9'h060;
      1: return 9'h008;
      2: return 9'h064 + 9'(s % 4);
      3: return 9'h068 + 9'(s % 4);
      4: return 9'h06C + 9'(s % 4);
      5: return 9'h030;
      6: return 9'h03E + 9'(s % 2);
      7: return 9'h180 + 9'(s % 128);
      default: return 9'(s);
    endcase
  endfunction

  task automatic doReset();
    rstN = 1'b0; trapReq = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mTl = 0; mPs = 12'h014; mHp = 12'h000;
    for (int i = 0; i < 8; i++) begin
      mWord[i] = '0; mPc[i] = '0; mNpc[i] = '0; mTt[i] = '0; mHt[i] = '0;
    end
  endtask

  task automatic doTrap(input logic [8:0] tt, input logic hm);
    logic [11:0] psR, ps, hp, hpOld;
    logic [63:0] ePc;
    bit entered;
    int k;
    @(negedge clk);
    trapType = tt; hyperMode = hm;
    ccr = 8'($urandom); asi = 8'($urandom); cwp = 5'($urandom);
    curPc = {$urandom, $urandom}; curNpc = {$urandom, $urandom};
    trapReq = 1'b1;
    entered = (mTl < MAXL);
    ePc = '0;
    if (entered) begin
      psR = mPs | ((mTl >= MAXL - 1) ? 12'h020 : 12'h000);
      hpOld = mHp;
      mTl++;
      mWord[mTl] = {ccr, asi, 4'b0, psR & 12'hF3F, 3'b0, cwp};
      mPc[mTl] = curPc; mNpc[mTl] = curNpc; mTt[mTl] = tt;
      hp = mHp; ps = psR;
      if (hyperPresent) begin
        mHt[mTl] = hpOld;
        if (mTl > 2) hp = hp | 12'h004;
      end
      k = kindOf(tt);
      if (k == 0) begin
        if (!hyperPresent) ps = 12'h814;
      end else if (k == 1) begin
        if (hyperPresent) begin hp = hp | 12'h004; ps = 12'h014; end
        else ps = 12'h414;
      end else if (k == 2) begin
        hp = hp | 12'h004;
      end else ps = 12'h015;
      mPs = ps; mHp = hp;
      ePc = vecOf(hm, tt, mTl);
    end
    @(negedge clk);
    trapReq = 1'b0;
    if (entered) begin
      chk("R11", "redirectValid", 64'(redirectValid), 64'd1);
      chk(hm ? "R9" : "R10", "redirectPc", redirectPc, ePc);
      chk("R10", "redirectNpc", redirectNpc, ePc + 64'd4);
      chk("R2", "trapLevel", 64'(trapLevel), 64'(mTl));
      chk("R6 R7 R8", "procState", 64'(procState), 64'(mPs));
      chk("R5 R7 R8", "hyperState", 64'(hyperState), 64'(mHp));
      chk("R1", "errorState", 64'(errorState), 64'd0);
      rdLevel = TW'(mTl);
      #1;
      chk("R3", "rdTstate", 64'(rdTstate), 64'(mWord[mTl]));
      chk("R4", "rdTpc", rdTpc, mPc[mTl]);
      chk("R4", "rdTnpc", rdTnpc, mNpc[mTl]);
      chk("R4", "rdTt", 64'(rdTt), 64'(mTt[mTl]));
      chk("R5", "rdHtstate", 64'(rdHtstate), 64'(mHt[mTl]));
    end else begin
      chk("R1", "errorState", 64'(errorState), 64'd1);
      chk("R1", "redirectValid", 64'(redirectValid), 64'd0);
      chk("R1", "trapLevel", 64'(trapLevel), 64'(mTl));
      chk("R1", "procState", 64'(procState), 64'(mPs));
      chk("R1", "hyperState", 64'(hyperState), 64'(mHp));
    end
    @(negedge clk);
    chk("R11", "redirectValid low after strobe", 64'(redirectValid), 64'd0);
  endtask

  task automatic checkStack();
    for (int i = 0; i < 8; i++) begin
      rdLevel = TW'(i);
      #1;
      chk("R4", "stack word", 64'(rdTstate), 64'(mWord[i]));
      chk("R4", "stack pc", rdTpc, mPc[i]);
      chk("R4", "stack tt", 64'(rdTt), 64'(mTt[i]));
      chk("R5", "stack hyper", 64'(rdHtstate), 64'(mHt[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    trapType = '0; hyperPresent = 1'b0; hyperMode = 1'b0;
    ccr = '0; asi = '0; cwp = '0; curPc = '0; curNpc = '0;
    trapBase = '1; hyperBase = '1; rdLevel = '0;
    doReset();
    @(negedge clk);
    // R12 reset state
    chk("R12", "trapLevel", 64'(trapLevel), 64'd0);
    chk("R12", "procState", 64'(procState), 64'h014);
    chk("R12", "hyperState", 64'(hyperState), 64'h0);
    chk("R12", "errorState", 64'(errorState), 64'd0);
    chk("R12", "redirectValid", 64'(redirectValid), 64'd0);
    checkStack();

    // directed: all-ones bases, every class, no hypervisor, then overflow (R1 R2 R6..R10)
    doTrap(9'h060, 1'b0);
    doTrap(9'h064, 1'b0);
    doTrap(9'h03E, 1'b1);
    doTrap(9'h1FF, 1'b0);
    doTrap(9'h041, 1'b0);
    doTrap(9'h06F, 1'b0);   // level 5 -> 6, reduced-reliability bit saved
    doTrap(9'h008, 1'b0);   // at ceiling: error
    doTrap(9'h030, 1'b1);
    checkStack();

    // directed: hypervisor present, forced privilege above level 2
    doReset();
    hyperPresent = 1'b1;
    doTrap(9'h041, 1'b0);
    doTrap(9'h060, 1'b1);
    doTrap(9'h041, 1'b0);
    doTrap(9'h06C, 1'b1);
    checkStack();

    // random runs
    for (int run = 0; run < 40; run++) begin
      doReset();
      hyperPresent = 1'($urandom);
      trapBase = {$urandom, $urandom};
      hyperBase = {$urandom, $urandom};
      for (int n = 0; n < 8; n++) doTrap(pickType(), 1'($urandom));
      checkStack();
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule